// File: doc/BRIEF.md
# Tree-Structured 16-to-1 Selector with Dual Enables

This block picks one bit out of sixteen data bits using a 4-bit select code and presents it on a single output. Internally it is not one flat selector: it is a tree of identical 4-to-1 leaf cells. Each leaf has its own active-high gate. The first rank of four leaves shares the two low select bits. A final leaf chooses among their results using the two high select bits.

Two enable pins of opposite polarity control the block. One is active-high and one is active-low. The selector only passes data while the high-true pin is 1 and the low-true pin is 0. In every other enable state the output is held at 0, whatever the select and data inputs are. The block has no clock and no storage, so the output follows its inputs directly. It suits any place where a wide one-bit choice is needed, or where a Boolean function of four variables is built by tying the data pins to constants.

Top module: `sel_tree_mux`

## Requirements
- R1: With `en_hi_i`=1 and `en_lo_n_i`=0, `y_o` equals `data_i[sel_i]` for every select value 0 to 15, where `data_i[n]` is bit n of the data bus.
- R2: With `en_hi_i`=0 and `en_lo_n_i`=0, `y_o` is 0 for every select value and data pattern.
- R3: With `en_hi_i`=1 and `en_lo_n_i`=1, `y_o` is 0 for every select value and data pattern.
- R4: With `en_hi_i`=0 and `en_lo_n_i`=1, `y_o` is 0 for every select value and data pattern.
- R5: `sel_i` is read as an unsigned binary number. Bits [1:0] choose a position within a group of four inputs, and bits [3:2] choose the group. So with a single data bit n set and the block enabled, `y_o` is 1 only when `sel_i` equals n.
- R6: The output is combinational. While the block is enabled, a change on `sel_i` or `data_i` shows up on `y_o` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 16 | Data bits; bit n is chosen when the select code is n |
| sel_i | input | 4 | Binary select code |
| en_hi_i | input | 1 | Active-high enable; it gates the first rank of leaves |
| en_lo_n_i | input | 1 | Active-low enable; it gates the final leaf |
| y_o | output | 1 | Chosen data bit, or 0 when disabled |

## Verification
The bench walks a single set bit across all sixteen data positions against every select code. A tree with swapped select pairs, or with a leaf wired to the wrong group of inputs, would pass the wrong bit and produce a 1 at the wrong select value. Each of the three disabled enable states is driven with data that is all ones, all zeros, or random. A block that ignored one enable pin, or inverted its polarity, would leak data onto the output in exactly one of those states. A select change made between clock edges checks that no hidden register delays the output by a cycle.

// File: rtl/sel_tree_pkg.sv
package sel_tree_pkg;
  localparam int DEF_SEL_W      = 4;
  localparam int DEF_LEAF_SEL_W = 2;

  function automatic int level_count(input int sel_w, input int leaf_sel_w);
    return sel_w / leaf_sel_w;
  endfunction

  function automatic int nodes_at(input int sel_w, input int leaf_sel_w, input int lvl);
    return (1 << sel_w) >> (leaf_sel_w * (lvl + 1));
  endfunction
endpackage

// File: rtl/sel_tree_leaf.sv
module sel_tree_leaf #(
  parameter int SEL_W = 2
) (
  input  logic [(1<<SEL_W)-1:0] d_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic                  en_i,
  output logic                  y_o
);
  always_comb begin
    if (en_i) y_o = d_i[sel_i];
    else      y_o = 1'b0;
  end
endmodule

// File: rtl/sel_tree_level.sv
module sel_tree_level #(
  parameter int LEAF_SEL_W = 2,
  parameter int NODES      = 4,
  localparam int LEAF_N    = 1 << LEAF_SEL_W
) (
  input  logic [NODES*LEAF_N-1:0] in_i,
  input  logic [LEAF_SEL_W-1:0]   sel_i,
  input  logic                    en_i,
  output logic [NODES-1:0]        out_o
);
  for (genvar k = 0; k < NODES; k++) begin : g_node
    sel_tree_leaf #(.SEL_W(LEAF_SEL_W)) u_leaf (
      .d_i  (in_i[k*LEAF_N +: LEAF_N]),
      .sel_i(sel_i),
      .en_i (en_i),
      .y_o  (out_o[k])
    );
  end
endmodule

// File: rtl/sel_tree_en_ctrl.sv
module sel_tree_en_ctrl (
  input  logic en_hi_i,
  input  logic en_lo_n_i,
  output logic first_en_o,
  output logic mid_en_o,
  output logic last_en_o
);
  // The high-true pin gates the first rank, the low-true pin the root.
  // Ranks in between have no enable of their own and stay asserted.
  assign first_en_o = en_hi_i;
  assign last_en_o  = ~en_lo_n_i;
  assign mid_en_o   = 1'b1;
endmodule

// File: rtl/sel_tree_mux.sv
module sel_tree_mux #(
  parameter int SEL_W      = sel_tree_pkg::DEF_SEL_W,
  parameter int LEAF_SEL_W = sel_tree_pkg::DEF_LEAF_SEL_W,
  localparam int N_IN      = 1 << SEL_W,
  localparam int LEAF_N    = 1 << LEAF_SEL_W,
  localparam int LEVELS    = sel_tree_pkg::level_count(SEL_W, LEAF_SEL_W),
  localparam int FIRST_N   = N_IN / LEAF_N
) (
  input  logic [N_IN-1:0]  data_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_hi_i,
  input  logic             en_lo_n_i,
  output logic             y_o
);
  logic first_en, mid_en, last_en;
  logic [FIRST_N-1:0] first_stage_y;

  sel_tree_en_ctrl u_en (
    .en_hi_i   (en_hi_i),
    .en_lo_n_i (en_lo_n_i),
    .first_en_o(first_en),
    .mid_en_o  (mid_en),
    .last_en_o (last_en)
  );

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int NODES = sel_tree_pkg::nodes_at(SEL_W, LEAF_SEL_W, l);
    logic [NODES*LEAF_N-1:0] lvl_in;
    logic [NODES-1:0]        lvl_out;
    logic                    lvl_en;

    if (l == 0) begin : g_src
      assign lvl_in = data_i;
    end else begin : g_src
      assign lvl_in = g_lvl[l-1].lvl_out;
    end

    if (LEVELS == 1) begin : g_en
      assign lvl_en = first_en & last_en;
    end else if (l == 0) begin : g_en
      assign lvl_en = first_en;
    end else if (l == LEVELS - 1) begin : g_en
      assign lvl_en = last_en;
    end else begin : g_en
      assign lvl_en = mid_en;
    end

    sel_tree_level #(.LEAF_SEL_W(LEAF_SEL_W), .NODES(NODES)) u_level (
      .in_i (lvl_in),
      .sel_i(sel_i[l*LEAF_SEL_W +: LEAF_SEL_W]),
      .en_i (lvl_en),
      .out_o(lvl_out)
    );
  end

  assign first_stage_y = g_lvl[0].lvl_out;
  assign y_o           = g_lvl[LEVELS-1].lvl_out[0];
endmodule

// File: rtl/sel_tree_mux_chk.sv
module sel_tree_mux_chk #(
  parameter int SEL_W      = 4,
  parameter int LEAF_SEL_W = 2,
  localparam int N_IN      = 1 << SEL_W,
  localparam int LEAF_N    = 1 << LEAF_SEL_W,
  localparam int FIRST_N   = N_IN / LEAF_N
) (
  input logic [N_IN-1:0]    data_i,
  input logic [SEL_W-1:0]   sel_i,
  input logic               en_hi_i,
  input logic               en_lo_n_i,
  input logic               y_o,
  input logic [FIRST_N-1:0] first_i
);
  always_comb begin
    if (en_hi_i && !en_lo_n_i)
      assert_pick_R1: assert (y_o == data_i[sel_i])
        else $error("R1 chosen bit mismatch");
    if (!en_hi_i && !en_lo_n_i)
      assert_hi_off_R2: assert (y_o == 1'b0)
        else $error("R2 output not forced low");
    if (en_lo_n_i)
      assert_lo_off_R3: assert (y_o == 1'b0)
        else $error("R3 output not forced low");
    if (!en_hi_i && en_lo_n_i)
      assert_both_off_R4: assert (y_o == 1'b0)
        else $error("R4 output not forced low");
    for (int k = 0; k < FIRST_N; k++) begin
      if (en_hi_i)
        assert_group_pick_R5: assert (first_i[k] == data_i[k*LEAF_N + int'(sel_i[LEAF_SEL_W-1:0])])
          else $error("R5 first rank leaf %0d mismatch", k);
      else
        assert_group_gate_R2: assert (first_i[k] == 1'b0)
          else $error("R2 first rank leaf %0d not gated", k);
    end
  end
endmodule

bind sel_tree_mux sel_tree_mux_chk #(.SEL_W(SEL_W), .LEAF_SEL_W(LEAF_SEL_W)) u_chk (
  .data_i   (data_i),
  .sel_i    (sel_i),
  .en_hi_i  (en_hi_i),
  .en_lo_n_i(en_lo_n_i),
  .y_o      (y_o),
  .first_i  (first_stage_y)
);

// File: tb/sel_tree_mux_bench.sv
module sel_tree_mux_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] data;
  logic [3:0]  sel;
  logic        en_hi;
  logic        en_lo_n;
  logic        y;

  int checks   = 0;
  int failures = 0;
  bit exp_q[$];
  string tag_q[$];
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sel_tree_mux u_sel_tree_mux (
    .data_i   (data),
    .sel_i    (sel),
    .en_hi_i  (en_hi),
    .en_lo_n_i(en_lo_n),
    .y_o      (y)
  );

  function automatic bit model(input logic [15:0] d, input logic [3:0] s,
                               input logic gh, input logic gl);
    return (gh && !gl) ? d[s] : 1'b0;
  endfunction

  task automatic compare(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: y=%0b expected=%0b (data=%h sel=%0d en_hi=%0b en_lo_n=%0b)",
               tag, act, exp, data, sel, en_hi, en_lo_n);
    end
  endtask

  // Driver: apply one vector per cycle and queue its expected output
  task automatic drive(input logic [15:0] d, input logic [3:0] s,
                       input logic gh, input logic gl, input string tag);
    @(posedge clk);
    data = d; sel = s; en_hi = gh; en_lo_n = gl;
    exp_q.push_back(model(d, s, gh, gl));
    tag_q.push_back(tag);
  endtask

  // Monitor: compare on the falling edge, half a cycle after driving
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      compare(y, e, t);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: cycles=%0d expected=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    data = '0; sel = '0; en_hi = 1'b0; en_lo_n = 1'b1;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #5;
    compare(y, 1'b0, "R4 idle state");

    // R1: all selects, several data patterns
    for (int p = 0; p < 4; p++) begin
      logic [15:0] pat;
      pat = (p == 0) ? 16'hA5C3 : (p == 1) ? 16'h5A3C : 16'($urandom);
      for (int s = 0; s < 16; s++) drive(pat, 4'(s), 1'b1, 1'b0, "R1");
    end

    // R5: walking one against every select
    for (int n = 0; n < 16; n++)
      for (int s = 0; s < 16; s++)
        drive(16'(1) << n, 4'(s), 1'b1, 1'b0, "R5");

    // R2, R3, R4: disabled states with ones, zeros and random data
    for (int p = 0; p < 3; p++) begin
      logic [15:0] pat;
      pat = (p == 0) ? 16'hFFFF : (p == 1) ? 16'h0000 : 16'($urandom);
      for (int s = 0; s < 16; s++) begin
        drive(pat, 4'(s), 1'b0, 1'b0, "R2");
        drive(pat, 4'(s), 1'b1, 1'b1, "R3");
        drive(pat, 4'(s), 1'b0, 1'b1, "R4");
      end
    end

    // R6: changes between clock edges reach the output directly
    @(posedge clk);
    while (exp_q.size() > 0) @(posedge clk);
    #2;
    data = 16'h0080; sel = 4'd7; en_hi = 1'b1; en_lo_n = 1'b0;
    #2 compare(y, 1'b1, "R6 select 7");
    sel = 4'd9;
    #2 compare(y, 1'b0, "R6 select 9");
    data = 16'h0200;
    #2 compare(y, 1'b1, "R6 data change");
    en_lo_n = 1'b1;
    #2 compare(y, 1'b0, "R6 R3 enable drop");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule